// File: doc/BRIEF.md
# I2C Target Header Acknowledge Controller

This block is the decision and handshake core of an I2C target. A byte-level bus engine in front of it reports each received address header (a 7-bit address and a read/write bit) and each data-byte event. For every header the block answers with a one-cycle ACK or NACK pulse, or it stalls the bus engine and raises a pending flag that also drives an interrupt. Software then services the transfer and releases the stall through a self-clearing continue command or a self-clearing NACK command.

Two registers sit behind a simple register port: a control register and a primary-address register. An automatic mode lets a header be ACKed with no software involvement when both its address and a preselected transfer direction match. When only the address matches, a per-address auto-NACK bit picks between rejecting the header and handing it to software. Data-byte events either raise DMA requests, when DMA is enabled, or raise the pending flag for software service.

Top module: `i2c_tgt_hdr_ctrl`

## Requirements
- R1: After reset both registers read 0, and the outputs hdr_ack, hdr_nack, pending, irq, stall, cmd_go, cmd_nack, dma_rx_req and dma_tx_req are all 0.
- R2: With reg_sel=0 the control register is accessed: bit 3 is DMA enable, bit 8 is automatic mode, bit 9 is the expected direction (1 = read, 0 = write), and these three bits read back as written. Bits 0 (continue) and 1 (NACK) are one-cycle command strobes that read as 0, and every other bit reads as 0. With reg_sel=1 the address register is accessed: bits 7:1 hold the primary address and bit 0 the auto-NACK bit. All other bits read as 0. reg_rdata shows the register picked by reg_sel, and a write takes effect on the next clock.
- R3: A header whose address differs from the primary address gives a hdr_nack pulse and leaves pending unchanged.
- R4: A header decision appears as a pulse of exactly one cycle on hdr_ack or hdr_nack, never on both, in the cycle after hdr_valid. With automatic mode on, a header whose address and direction bit both match is ACKed and does not set pending.
- R5: With automatic mode on, a header whose address matches and whose direction bit differs is NACKed if auto-NACK is 1. If auto-NACK is 0, it sets pending and irq instead.
- R6: With automatic mode off, a header whose address matches sets pending and irq if auto-NACK is 0, and is NACKed if auto-NACK is 1. A pending state becomes visible in the same cycle that the decision pulse would appear.
- R7: stall is high exactly while pending is 1 and no command is being accepted. A continue write is accepted only while pending is 1. When accepted, it pulses cmd_go, drops stall in the write cycle and clears pending on the next cycle. A continue write with pending at 0 has no effect.
- R8: A NACK write is accepted only while pending is 1 and the last accepted header was a write (direction bit 0). When accepted, it pulses cmd_nack, drops stall and clears pending, and it suppresses cmd_go for that same write. Otherwise it has no effect, and stall and pending stay high.
- R9: While DMA enable is 1, rx_byte_valid or tx_byte_need gives a one-cycle dma_rx_req or dma_tx_req in the next cycle, and pending is not set. While DMA enable is 0, no DMA request appears and the event sets pending.
- R10: When a pending-setting event and an accepted continue fall in the same cycle, pending is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data of the selected register |
| hdr_valid | input | 1 | Header received strobe |
| hdr_addr | input | ADDR_W | Received header address |
| hdr_rnw | input | 1 | Header direction bit, 1 = read |
| rx_byte_valid | input | 1 | Data byte received from master |
| tx_byte_need | input | 1 | Bus engine needs a byte to transmit |
| hdr_ack | output | 1 | ACK the header (one-cycle pulse) |
| hdr_nack | output | 1 | NACK the header (one-cycle pulse) |
| pending | output | 1 | Software service pending |
| irq | output | 1 | Interrupt, follows pending |
| stall | output | 1 | Hold the bus engine |
| cmd_go | output | 1 | Continue accepted (pulse) |
| cmd_nack | output | 1 | NACK master data accepted (pulse) |
| dma_rx_req | output | 1 | DMA request for received data |
| dma_tx_req | output | 1 | DMA request for transmit data |

## Verification
A continue command can land in the same cycle as a new data event that wants to raise pending again. This happens while the current pending flag is being released, and it decides whether the second event is lost. The bench provokes it by writing continue in the very cycle rx_byte_valid arrives with DMA disabled. It then judges that cmd_go pulses and stall drops in that cycle, and that pending is still 1 on the next cycle. A header strobe coinciding with a register write is also exercised, where the decision must use the register values from before the write.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  // control register bit positions (software-visible encoding)
  localparam int CTL_CONT_BIT = 0;
  localparam int CTL_NACK_BIT = 1;
  localparam int CTL_DMA_BIT  = 3;
  localparam int CTL_AUTO_BIT = 8;
  localparam int CTL_DIR_BIT  = 9;

  typedef enum logic [1:0] {
    HD_NACK = 2'd0,
    HD_ACK  = 2'd1,
    HD_PEND = 2'd2
  } hdr_dec_e;

  // header verdict from address match, mode and direction settings
  function automatic hdr_dec_e hdr_decide(
    input logic match,
    input logic auto_en,
    input logic exp_rd,
    input logic rnw,
    input logic auto_nack
  );
    hdr_dec_e d;
    if (!match)
      d = HD_NACK;
    else if (auto_en && (rnw == exp_rd))
      d = HD_ACK;
    else if (auto_nack)
      d = HD_NACK;
    else
      d = HD_PEND;
    return d;
  endfunction

endpackage

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              dma_en,
  output logic              auto_en,
  output logic              exp_rd,
  output logic [ADDR_W-1:0] prim_addr,
  output logic              auto_nack,
  output logic              cont_stb,
  output logic              nack_stb
);

  logic wr_ctl, wr_adr;

  assign wr_ctl = wr && !sel;
  assign wr_adr = wr && sel;

  // command strobes act only in the write cycle and are never stored
  assign cont_stb = wr_ctl && wdata[CTL_CONT_BIT];
  assign nack_stb = wr_ctl && wdata[CTL_NACK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_en  <= 1'b0;
      auto_en <= 1'b0;
      exp_rd  <= 1'b0;
    end else if (wr_ctl) begin
      dma_en  <= wdata[CTL_DMA_BIT];
      auto_en <= wdata[CTL_AUTO_BIT];
      exp_rd  <= wdata[CTL_DIR_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prim_addr <= '0;
      auto_nack <= 1'b0;
    end else if (wr_adr) begin
      prim_addr <= wdata[ADDR_W:1];
      auto_nack <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    if (!sel) begin
      rdata[CTL_DMA_BIT]  = dma_en;
      rdata[CTL_AUTO_BIT] = auto_en;
      rdata[CTL_DIR_BIT]  = exp_rd;
    end else begin
      rdata[ADDR_W:1] = prim_addr;
      rdata[0]        = auto_nack;
    end
  end

endmodule

// File: rtl/i2c_tgt_hdr_dec.sv
module i2c_tgt_hdr_dec
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic              hdr_rnw,
  input  logic [ADDR_W-1:0] prim_addr,
  input  logic              auto_en,
  input  logic              exp_rd,
  input  logic              auto_nack,
  output logic              hdr_ack,
  output logic              hdr_nack,
  output logic              set_pend,
  output logic              take_hdr
);

  hdr_dec_e verdict;
  logic     addr_hit;

  assign addr_hit = (hdr_addr == prim_addr);
  assign verdict  = hdr_decide(addr_hit, auto_en, exp_rd, hdr_rnw, auto_nack);

  // header accepted (ACK or handed to software) records the direction
  assign set_pend = hdr_valid && (verdict == HD_PEND);
  assign take_hdr = hdr_valid && (verdict != HD_NACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_ack  <= 1'b0;
      hdr_nack <= 1'b0;
    end else begin
      hdr_ack  <= hdr_valid && (verdict == HD_ACK);
      hdr_nack <= hdr_valid && (verdict == HD_NACK);
    end
  end

endmodule

// File: rtl/i2c_tgt_pend.sv
module i2c_tgt_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic hdr_set_pend,
  input  logic take_hdr,
  input  logic hdr_rnw,
  input  logic cont_stb,
  input  logic nack_stb,
  input  logic rx_byte_valid,
  input  logic tx_byte_need,
  input  logic dma_en,
  output logic pending,
  output logic stall,
  output logic cmd_go,
  output logic cmd_nack,
  output logic dma_rx_req,
  output logic dma_tx_req,
  output logic rx_dir
);

  logic nack_acc, cont_acc, clr_pend, data_set, pend_set;

  assign nack_acc = nack_stb && pending && rx_dir;
  assign cont_acc = cont_stb && pending && !nack_acc;
  assign clr_pend = nack_acc || cont_acc;

  assign data_set = !dma_en && (rx_byte_valid || tx_byte_need);
  assign pend_set = hdr_set_pend || data_set;

  assign stall    = pending && !clr_pend;
  assign cmd_go   = cont_acc;
  assign cmd_nack = nack_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending    <= 1'b0;
      rx_dir     <= 1'b0;
      dma_rx_req <= 1'b0;
      dma_tx_req <= 1'b0;
    end else begin
      // a new set event wins over a release in the same cycle
      pending    <= pend_set || (pending && !clr_pend);
      if (take_hdr)
        rx_dir   <= !hdr_rnw;
      dma_rx_req <= dma_en && rx_byte_valid;
      dma_tx_req <= dma_en && tx_byte_need;
    end
  end

endmodule

// File: rtl/i2c_tgt_hdr_ctrl.sv
module i2c_tgt_hdr_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              hdr_valid,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic              hdr_rnw,
  input  logic              rx_byte_valid,
  input  logic              tx_byte_need,
  output logic              hdr_ack,
  output logic              hdr_nack,
  output logic              pending,
  output logic              irq,
  output logic              stall,
  output logic              cmd_go,
  output logic              cmd_nack,
  output logic              dma_rx_req,
  output logic              dma_tx_req
);

  logic              dma_en_w, auto_en_w, exp_rd_w, auto_nack_w;
  logic [ADDR_W-1:0] prim_addr_w;
  logic              cont_stb_w, nack_stb_w;
  logic              set_pend_w, take_hdr_w, rx_dir_w;

  i2c_tgt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .sel       (reg_sel),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .dma_en    (dma_en_w),
    .auto_en   (auto_en_w),
    .exp_rd    (exp_rd_w),
    .prim_addr (prim_addr_w),
    .auto_nack (auto_nack_w),
    .cont_stb  (cont_stb_w),
    .nack_stb  (nack_stb_w)
  );

  i2c_tgt_hdr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_valid (hdr_valid),
    .hdr_addr  (hdr_addr),
    .hdr_rnw   (hdr_rnw),
    .prim_addr (prim_addr_w),
    .auto_en   (auto_en_w),
    .exp_rd    (exp_rd_w),
    .auto_nack (auto_nack_w),
    .hdr_ack   (hdr_ack),
    .hdr_nack  (hdr_nack),
    .set_pend  (set_pend_w),
    .take_hdr  (take_hdr_w)
  );

  i2c_tgt_pend u_pend (
    .clk           (clk),
    .rst_n         (rst_n),
    .hdr_set_pend  (set_pend_w),
    .take_hdr      (take_hdr_w),
    .hdr_rnw       (hdr_rnw),
    .cont_stb      (cont_stb_w),
    .nack_stb      (nack_stb_w),
    .rx_byte_valid (rx_byte_valid),
    .tx_byte_need  (tx_byte_need),
    .dma_en        (dma_en_w),
    .pending       (pending),
    .stall         (stall),
    .cmd_go        (cmd_go),
    .cmd_nack      (cmd_nack),
    .dma_rx_req    (dma_rx_req),
    .dma_tx_req    (dma_tx_req),
    .rx_dir        (rx_dir_w)
  );

  assign irq = pending;

endmodule

// File: rtl/i2c_tgt_hdr_chk.sv
module i2c_tgt_hdr_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              hdr_valid,
  input logic [ADDR_W-1:0] hdr_addr,
  input logic              rx_byte_valid,
  input logic              tx_byte_need,
  input logic              hdr_ack,
  input logic              hdr_nack,
  input logic              pending,
  input logic              stall,
  input logic              cmd_go,
  input logic              cmd_nack,
  input logic              dma_rx_req,
  input logic              dma_tx_req,
  input logic              dma_en_w,
  input logic [ADDR_W-1:0] prim_addr_w,
  input logic              rx_dir_w
);

  p_one_verdict_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_ack && hdr_nack));

  p_verdict_timing_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_ack || hdr_nack) |-> $past(hdr_valid));

  p_foreign_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && (hdr_addr != prim_addr_w) && !reg_wr && !rx_byte_valid && !tx_byte_need)
      |=> (hdr_nack && (pending == $past(pending))));

  p_stall_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> pending);

  p_go_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |-> (pending && !stall && !cmd_nack));

  p_nack_dir_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_nack |-> (pending && rx_dir_w && !stall));

  p_dma_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_rx_req || dma_tx_req) |-> $past(dma_en_w));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !dma_en_w && (rx_byte_valid || tx_byte_need)) |=> pending);

endmodule

bind i2c_tgt_hdr_ctrl i2c_tgt_hdr_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr        (reg_wr),
  .hdr_valid     (hdr_valid),
  .hdr_addr      (hdr_addr),
  .rx_byte_valid (rx_byte_valid),
  .tx_byte_need  (tx_byte_need),
  .hdr_ack       (hdr_ack),
  .hdr_nack      (hdr_nack),
  .pending       (pending),
  .stall         (stall),
  .cmd_go        (cmd_go),
  .cmd_nack      (cmd_nack),
  .dma_rx_req    (dma_rx_req),
  .dma_tx_req    (dma_tx_req),
  .dma_en_w      (dma_en_w),
  .prim_addr_w   (prim_addr_w),
  .rx_dir_w      (rx_dir_w)
);

// File: tb/i2c_tgt_hdr_ctrl_test.sv
module i2c_tgt_hdr_ctrl_test;

  localparam int DW = 32;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_sel = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          hdr_valid = 1'b0, hdr_rnw = 1'b0;
  logic [AW-1:0] hdr_addr = '0;
  logic          rx_byte_valid = 1'b0, tx_byte_need = 1'b0;
  logic          hdr_ack, hdr_nack, pending, irq, stall, cmd_go, cmd_nack;
  logic          dma_rx_req, dma_tx_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // sampled during the write cycle of the last register write
  logic s_stall, s_go, s_nack;

  always #10 clk = ~clk;

  i2c_tgt_hdr_ctrl #(.DATA_W(DW), .ADDR_W(AW)) uut (.*);

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // 0 = ACK, 1 = NACK, 2 = pending; restated from the requirements
  function automatic int expect_kind(bit auto_m, bit want_rd, bit an, bit same_addr, bit rd);
    if (same_addr == 1'b0) return 1;
    if (auto_m && want_rd == rd) return 0;
    return an ? 1 : 2;
  endfunction

  function automatic logic [31:0] ctl_word(bit dma, bit auto_m, bit want_rd, bit go, bit nk);
    logic [31:0] w = '0;
    w[3] = dma; w[8] = auto_m; w[9] = want_rd; w[0] = go; w[1] = nk;
    return w;
  endfunction

  task automatic reg_write(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    #1;
    s_stall = stall; s_go = cmd_go; s_nack = cmd_nack;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic send_hdr(input logic [AW-1:0] a, input bit rd);
    @(negedge clk);
    hdr_valid = 1'b1; hdr_addr = a; hdr_rnw = rd;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic check_kind(input string req, input int kind);
    check(req, "hdr_ack",  hdr_ack,  kind == 0);
    check(req, "hdr_nack", hdr_nack, kind == 1);
    check(req, "pending",  pending,  kind == 2);
    check(req, "irq",      irq,      kind == 2);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "ctl read", reg_rdata, 32'h0);
    reg_sel = 1'b1; #1;
    check("R1", "adr read", reg_rdata, 32'h0);
    check("R1", "outputs", {hdr_ack, hdr_nack, pending, irq, stall, cmd_go, cmd_nack, dma_rx_req, dma_tx_req}, 0);
    reg_sel = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    // R2 readback; strobe bits and unused bits read 0
    reg_write(1'b0, 32'hFFFF_FFFF);
    reg_sel = 1'b0; #1;
    check("R2", "ctl readback", reg_rdata, 32'h0000_0308);
    reg_write(1'b1, 32'hFFFF_FF55);
    reg_sel = 1'b1; #1;
    check("R2", "adr readback", reg_rdata, 32'h0000_0055);

    // R3 foreign address, pending unchanged
    reg_write(1'b0, ctl_word(0, 0, 0, 0, 0));
    reg_write(1'b1, {24'h0, 7'h2A, 1'b0});
    send_hdr(7'h2B, 1'b0);
    check_kind("R3", 1);

    // R4 auto mode, address and direction match
    reg_write(1'b0, ctl_word(0, 1, 1, 0, 0));
    send_hdr(7'h2A, 1'b1);
    check_kind("R4", 0);
    @(negedge clk);
    check("R4", "ack one cycle", hdr_ack, 1'b0);

    // R5 auto mode, direction mismatch
    reg_write(1'b1, {24'h0, 7'h2A, 1'b1});
    send_hdr(7'h2A, 1'b0);
    check_kind("R5", 1);
    reg_write(1'b1, {24'h0, 7'h2A, 1'b0});
    send_hdr(7'h2A, 1'b0);
    check_kind("R5", 2);

    // R3 foreign header while pending leaves pending set
    send_hdr(7'h11, 1'b0);
    check("R3", "nack while pend", hdr_nack, 1'b1);
    check("R3", "pend kept", pending, 1'b1);

    // R8 NACK accepted: last accepted header was a write
    #1; check("R7", "stall while pend", stall, 1'b1);
    reg_write(1'b0, ctl_word(0, 1, 1, 1, 1));
    check("R8", "cmd_nack", s_nack, 1'b1);
    check("R8", "cmd_go suppressed", s_go, 1'b0);
    check("R8", "stall drop", s_stall, 1'b0);
    check("R8", "pend cleared", pending, 1'b0);

    // R6 normal mode; read header pending, NACK write ignored
    reg_write(1'b0, ctl_word(0, 0, 0, 0, 0));
    send_hdr(7'h2A, 1'b1);
    check_kind("R6", 2);
    reg_write(1'b0, ctl_word(0, 0, 0, 0, 1));
    check("R8", "nack ignored", s_nack, 1'b0);
    check("R8", "stall kept", s_stall, 1'b1);
    check("R8", "pend kept", pending, 1'b1);
    // R7 continue accepted
    reg_write(1'b0, ctl_word(0, 0, 0, 1, 0));
    check("R7", "cmd_go", s_go, 1'b1);
    check("R7", "stall drop", s_stall, 1'b0);
    check("R7", "pend cleared", pending, 1'b0);
    // R7 continue without pending has no effect
    reg_write(1'b0, ctl_word(0, 0, 0, 1, 0));
    check("R7", "idle go", s_go, 1'b0);
    check("R7", "idle pend", pending, 1'b0);
    reg_write(1'b1, {24'h0, 7'h2A, 1'b1});
    send_hdr(7'h2A, 1'b0);
    check_kind("R6", 1);

    // R9 DMA enabled and disabled
    reg_write(1'b0, ctl_word(1, 0, 0, 0, 0));
    @(negedge clk); rx_byte_valid = 1'b1;
    @(negedge clk); rx_byte_valid = 1'b0;
    check("R9", "dma_rx_req", dma_rx_req, 1'b1);
    check("R9", "no pend dma", pending, 1'b0);
    @(negedge clk); tx_byte_need = 1'b1;
    @(negedge clk); tx_byte_need = 1'b0;
    check("R9", "dma_tx_req", dma_tx_req, 1'b1);
    @(negedge clk);
    check("R9", "dma pulse", dma_tx_req, 1'b0);
    reg_write(1'b0, ctl_word(0, 0, 0, 0, 0));
    @(negedge clk); tx_byte_need = 1'b1;
    @(negedge clk); tx_byte_need = 1'b0;
    check("R9", "no dma req", dma_tx_req, 1'b0);
    check("R9", "pend by data", pending, 1'b1);

    // R10 continue and data event in the same cycle
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = ctl_word(0, 0, 0, 1, 0); rx_byte_valid = 1'b1;
    #1;
    check("R10", "cmd_go", cmd_go, 1'b1);
    check("R10", "stall drop", stall, 1'b0);
    @(negedge clk);
    reg_wr = 1'b0; rx_byte_valid = 1'b0;
    check("R10", "set wins", pending, 1'b1);
    reg_write(1'b0, ctl_word(0, 0, 0, 1, 0));

    // R4 header in same cycle as a config write uses old settings
    reg_write(1'b1, {24'h0, 7'h30, 1'b1});
    reg_write(1'b0, ctl_word(0, 1, 0, 0, 0));
    @(negedge clk);
    hdr_valid = 1'b1; hdr_addr = 7'h30; hdr_rnw = 1'b0;
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = ctl_word(0, 0, 0, 0, 0);
    @(negedge clk);
    hdr_valid = 1'b0; reg_wr = 1'b0;
    check_kind("R4", 0);

    // random headers against the bench model
    for (int i = 0; i < 200; i++) begin
      bit am = $urandom % 2, wr_rd = $urandom % 2, an = $urandom % 2;
      bit hit = $urandom % 2, rd = $urandom % 2;
      logic [AW-1:0] pa = AW'($urandom);
      logic [AW-1:0] ha = hit ? pa : (pa ^ AW'(1 + $urandom % 127));
      int k;
      reg_write(1'b0, ctl_word(0, am, wr_rd, 0, 0));
      reg_write(1'b1, {24'h0, pa, an});
      send_hdr(ha, rd);
      k = expect_kind(am, wr_rd, an, hit, rd);
      if (k == 0) check("R4", "rand", {hdr_ack, hdr_nack, pending}, 3'b100);
      else if (k == 1) check(hit ? "R5" : "R3", "rand", {hdr_ack, hdr_nack, pending}, 3'b010);
      else check("R6", "rand", {hdr_ack, hdr_nack, pending}, 3'b001);
      if (pending) begin
        reg_write(1'b0, ctl_word(0, am, wr_rd, 1, 0));
        check("R7", "rand go", {s_go, pending}, 2'b10);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule